// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block sets the pace of a small sequencing core. It alternates between a fetch phase and an execute phase. Each phase lasts a set number of clock cycles, and the controller owns the cycle counts for both. When a fetch ends, it samples the instruction class that the decoder presents. From that class it sets how long execution lasts. When execution ends, the same class sets whether the next fetch is short or long. Decoding and the datapath live elsewhere. This block only says when fetching happens, when execution is busy, and when the core is idle.

Three instruction classes do more than spend time:

- A wait instruction stretches execution by its count operand.
- A halt instruction parks the core. If the wakeup timer is enabled, it also sends that timer a one-cycle re-arm pulse. Only an external start pulse brings the core out of the parked state.
- A sleep instruction picks one of five period values, supplied from outside, as the wakeup period. The chosen value is driven on an output.

The shared memory belongs first to a higher-priority master. While the bus grant is low, any phase that touches memory holds its cycle counter where it is, so the phase is stretched and not lost.

Top module: `seq_cycle_timer`

## Requirements
- R1: After reset, halted_o is 1; fetch_en_o, exec_busy_o and timer_restart_o are 0; period_o shows period slot 0.
- R2: Class codes on ins_class_i are: 0 arithmetic, 1 branch, 2 memory, 3 wait, 4 halt, 5 sleep, 6 and 7 other. The fetch after an arithmetic or branch instruction holds fetch_en_o for 2 granted cycles. The fetch after any other class holds it for 4 granted cycles.
- R3: exec_busy_o stays high for 2 cycles for arithmetic, branch, halt, sleep and other classes. It stays high for MEM_EXEC granted cycles (default 4) for the memory class.
- R4: A wait instruction keeps exec_busy_o high for 2 + wait_cnt_i cycles. A count of 0 gives exactly 2 cycles. The fetch that follows a wait lasts 4 cycles.
- R5: Once a halt instruction finishes executing, halted_o stays 1 until start_i is sampled high. That start begins a 4-cycle fetch. start_i has no effect while the core is not halted.
- R6: timer_restart_o pulses for exactly one cycle. The pulse comes in the first halted cycle after a halt instruction, and only if timer_en_i is 1.
- R7: A sleep instruction with select value 0 to 4 makes period_o show that slot (slot k is bits k*PW and up of period_regs_i) from the cycle after its execution ends. A select value above 4 leaves the selection unchanged.
- R8: Each cycle with bus_grant_i low during a fetch freezes the fetch counter. The fetch is stretched by one cycle for each such cycle.
- R9: bus_grant_i low during execution of a memory-class instruction stretches execution by one cycle for each such cycle. During execution of any other class it has no effect.
- R10: The instruction fields (ins_class_i, wait_cnt_i, sleep_sel_i) are sampled on the last granted fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Leaves the halted state |
| ins_class_i | input | 3 | Decoded instruction class |
| wait_cnt_i | input | WAIT_W | Wait instruction count operand |
| sleep_sel_i | input | SEL_W | Sleep instruction period select |
| period_regs_i | input | NREG*PW | Packed period slots, slot k at bits k*PW |
| timer_en_i | input | 1 | Wakeup timer enabled |
| bus_grant_i | input | 1 | Shared memory granted to this core |
| fetch_en_o | output | 1 | Fetch phase active |
| exec_busy_o | output | 1 | Execute phase active |
| halted_o | output | 1 | Core parked |
| timer_restart_o | output | 1 | One-cycle wakeup timer re-arm |
| period_o | output | PW | Selected wakeup period |

## Verification
The assertions take for granted that the instruction fields stay steady for the whole fetch in which they are sampled. They also assume bus_grant_i changes only at cycle boundaries, and that the decoder never sees a class outside the three-bit code space. The bench meets these assumptions as follows:

- It drives every field once, at the falling edge before a fetch starts, and holds it until that instruction has finished executing.
- It lowers the grant only for a known number of leading cycles of a phase. It then counts fetch and execute cycles at falling edges and compares them with lengths worked out from the class, the count operand and the number of injected stall cycles.

// File: rtl/seq_timing_pkg.sv
// Package: shared class codes, phase encoding and fixed timing constants
// for the instruction cycle timing sequencer.
package seq_timing_pkg;

    typedef enum logic [2:0] {
        CLS_ALU    = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_MEM    = 3'd2,
        CLS_WAIT   = 3'd3,
        CLS_HALT   = 3'd4,
        CLS_SLEEP  = 3'd5,
        CLS_MISC   = 3'd6,
        CLS_RSVD   = 3'd7
    } ins_class_e;

    typedef enum logic [1:0] {
        PH_HALT  = 2'd0,
        PH_FETCH = 2'd1,
        PH_EXEC  = 2'd2
    } phase_e;

    localparam int SHORT_FETCH = 2;
    localparam int LONG_FETCH  = 4;
    localparam int BASE_EXEC   = 2;

    // True when the completed class allows the short fetch.
    function automatic logic takes_short_fetch(input ins_class_e c);
        return (c == CLS_ALU) || (c == CLS_BRANCH);
    endfunction

endpackage

// File: rtl/seq_len_calc.sv
// Module: seq_len_calc
// Works out, combinationally, two phase lengths. The execute length comes
// from the class and count now on the inputs. The next fetch length comes
// from the class that is finishing execution.
// Assumes: LEN_W can hold BASE_EXEC + the largest wait count and MEM_EXEC.
module seq_len_calc
    import seq_timing_pkg::*;
#(
    parameter int WAIT_W   = 8,
    parameter int MEM_EXEC = 4,
    parameter int LEN_W    = WAIT_W + 2
) (
    input  logic [2:0]        ins_class_i,
    input  logic [WAIT_W-1:0] wait_cnt_i,
    input  ins_class_e        done_class_i,
    output logic [LEN_W-1:0]  exec_len_o,
    output logic [LEN_W-1:0]  fetch_len_o
);

    ins_class_e cls_in;

    // Give the raw class bits their enum type.
    always_comb cls_in = ins_class_e'(ins_class_i);

    // Execute length for the class being sampled.
    always_comb begin
        unique case (cls_in)
            CLS_WAIT: exec_len_o = LEN_W'(BASE_EXEC) + LEN_W'(wait_cnt_i);
            CLS_MEM:  exec_len_o = LEN_W'(MEM_EXEC);
            default:  exec_len_o = LEN_W'(BASE_EXEC);
        endcase
    end

    // Fetch length after the class that just finished executing.
    always_comb begin
        if (takes_short_fetch(done_class_i))
            fetch_len_o = LEN_W'(SHORT_FETCH);
        else
            fetch_len_o = LEN_W'(LONG_FETCH);
    end

endmodule

// File: rtl/seq_phase_ctrl.sv
// Module: seq_phase_ctrl
// Phase state machine and cycle counter. It moves halted -> fetch -> execute
// -> fetch ... and goes back to halted after a halt instruction. The
// counter advances only on granted cycles in memory-touching phases.
// Assumes: exec_len_i and fetch_len_i are at least 1 (always 2 or more here).
module seq_phase_ctrl
    import seq_timing_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             grant_i,
    input  logic             timer_en_i,
    input  logic [2:0]       ins_class_i,
    input  logic [LEN_W-1:0] exec_len_i,
    input  logic [LEN_W-1:0] fetch_len_i,
    output phase_e           phase_o,
    output ins_class_e       cls_q_o,
    output logic             fetch_last_o,
    output logic             exec_last_o,
    output logic             timer_restart_o
);

    phase_e           phase_q;
    ins_class_e       cls_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             restart_q;
    logic             advance;
    logic             at_end;

    // Decide whether this cycle counts toward the current phase.
    always_comb begin
        unique case (phase_q)
            PH_FETCH: advance = grant_i;
            PH_EXEC:  advance = grant_i || (cls_q != CLS_MEM);
            default:  advance = 1'b0;
        endcase
    end

    // Flag the final counted cycle of the phase.
    always_comb at_end = advance && (cnt_q == len_q - LEN_W'(1));

    // Step the phase, the counter, the latched class and the timer pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_HALT;
            cls_q     <= CLS_MISC;
            cnt_q     <= '0;
            len_q     <= LEN_W'(LONG_FETCH);
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            unique case (phase_q)
                PH_HALT: begin
                    if (start_i) begin
                        phase_q <= PH_FETCH;
                        cnt_q   <= '0;
                        len_q   <= LEN_W'(LONG_FETCH);
                    end
                end
                PH_FETCH: begin
                    if (at_end) begin
                        phase_q <= PH_EXEC;
                        cnt_q   <= '0;
                        len_q   <= exec_len_i;
                        cls_q   <= ins_class_e'(ins_class_i);
                    end else if (advance) begin
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                end
                PH_EXEC: begin
                    if (at_end) begin
                        cnt_q <= '0;
                        if (cls_q == CLS_HALT) begin
                            phase_q   <= PH_HALT;
                            restart_q <= timer_en_i;
                        end else begin
                            phase_q <= PH_FETCH;
                            len_q   <= fetch_len_i;
                        end
                    end else if (advance) begin
                        cnt_q <= cnt_q + LEN_W'(1);
                    end
                end
                default: phase_q <= PH_HALT;
            endcase
        end
    end

    assign phase_o         = phase_q;
    assign cls_q_o         = cls_q;
    assign fetch_last_o    = (phase_q == PH_FETCH) && at_end;
    assign exec_last_o     = (phase_q == PH_EXEC) && at_end;
    assign timer_restart_o = restart_q;

    // R8: an ungranted fetch cycle leaves the phase and its count untouched.
    p_stall_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FETCH && !grant_i) |=> (phase_q == PH_FETCH) && $stable(cnt_q));

    // R9: execution of a non-memory class advances every cycle.
    p_nonmem_nostall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXEC && cls_q != CLS_MEM && !at_end)
        |=> (cnt_q == $past(cnt_q) + LEN_W'(1)));

    // R5: the halted state holds without a start.
    p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HALT && !start_i) |=> (phase_q == PH_HALT));

    // R5: a start while halted enters fetch at once.
    p_start_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HALT && start_i) |=> (phase_q == PH_FETCH) && (cnt_q == '0));

    // R6: the timer pulse appears only on entry into the halted state.
    p_restart_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> (phase_q == PH_HALT) && ($past(phase_q) == PH_EXEC));

    // R3: every execute phase lasts at least the base length.
    p_exec_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FETCH && at_end) |=> (len_q >= LEN_W'(BASE_EXEC)));

endmodule

// File: rtl/seq_period_sel.sv
// Module: seq_period_sel
// Holds the wakeup period selection. It captures the sleep select value
// at the end of fetch, commits it when a sleep instruction finishes
// executing, and drives the selected slot of the packed period inputs.
// Assumes: commit_i is only raised after a capture for the same instruction.
module seq_period_sel #(
    parameter int PW    = 16,
    parameter int NREG  = 5,
    parameter int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic             commit_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [NREG*PW-1:0] period_regs_i,
    output logic [PW-1:0]    period_o
);

    logic [PW-1:0]    slot [NREG];
    logic [SEL_W-1:0] pend_q;
    logic [SEL_W-1:0] sel_q;
    logic             pend_ok;

    // Unpack the flat period bus into slots.
    for (genvar k = 0; k < NREG; k++) begin : g_slot
        assign slot[k] = period_regs_i[k*PW +: PW];
    end

    // Hold the select operand sampled at the end of fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= '0;
        else if (capture_i) pend_q <= sel_i;
    end

    // Accept only in-range indices.
    always_comb pend_ok = (int'(pend_q) < NREG);

    // Commit a valid selection when the sleep instruction finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)                  sel_q <= '0;
        else if (commit_i && pend_ok) sel_q <= pend_q;
    end

    // Drive the chosen period.
    always_comb period_o = slot[sel_q];

    // R7: the selection index never leaves the slot range.
    p_sel_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_q) < NREG);

    // R7: without a commit the selection does not move.
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(sel_q));

endmodule

// File: rtl/seq_cycle_timer.sv
// Module: seq_cycle_timer (top)
// Fetch/execute cycle timing controller. It combines the length
// calculator, the phase controller and the period selector, and turns
// the phase into the three one-hot status outputs.
// Assumes: instruction fields are held steady through the fetch that samples them.
module seq_cycle_timer
    import seq_timing_pkg::*;
#(
    parameter int WAIT_W   = 8,
    parameter int MEM_EXEC = 4,
    parameter int PW       = 16,
    parameter int NREG     = 5,
    localparam int SEL_W   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [2:0]         ins_class_i,
    input  logic [WAIT_W-1:0]  wait_cnt_i,
    input  logic [SEL_W-1:0]   sleep_sel_i,
    input  logic [NREG*PW-1:0] period_regs_i,
    input  logic               timer_en_i,
    input  logic               bus_grant_i,
    output logic               fetch_en_o,
    output logic               exec_busy_o,
    output logic               halted_o,
    output logic               timer_restart_o,
    output logic [PW-1:0]      period_o
);

    localparam int LEN_W = WAIT_W + 2;

    phase_e           phase;
    ins_class_e       cls_q;
    logic [LEN_W-1:0] exec_len;
    logic [LEN_W-1:0] fetch_len;
    logic             fetch_last;
    logic             exec_last;

    seq_len_calc #(
        .WAIT_W  (WAIT_W),
        .MEM_EXEC(MEM_EXEC),
        .LEN_W   (LEN_W)
    ) len_i (
        .ins_class_i (ins_class_i),
        .wait_cnt_i  (wait_cnt_i),
        .done_class_i(cls_q),
        .exec_len_o  (exec_len),
        .fetch_len_o (fetch_len)
    );

    seq_phase_ctrl #(
        .LEN_W(LEN_W)
    ) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .grant_i        (bus_grant_i),
        .timer_en_i     (timer_en_i),
        .ins_class_i    (ins_class_i),
        .exec_len_i     (exec_len),
        .fetch_len_i    (fetch_len),
        .phase_o        (phase),
        .cls_q_o        (cls_q),
        .fetch_last_o   (fetch_last),
        .exec_last_o    (exec_last),
        .timer_restart_o(timer_restart_o)
    );

    seq_period_sel #(
        .PW   (PW),
        .NREG (NREG),
        .SEL_W(SEL_W)
    ) per_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_i    (fetch_last),
        .commit_i     (exec_last && (cls_q == CLS_SLEEP)),
        .sel_i        (sleep_sel_i),
        .period_regs_i(period_regs_i),
        .period_o     (period_o)
    );

    // Decode the phase into status outputs.
    always_comb begin
        fetch_en_o  = (phase == PH_FETCH);
        exec_busy_o = (phase == PH_EXEC);
        halted_o    = (phase == PH_HALT);
    end

    // R2: the status outputs are mutually exclusive and one is always set.
    p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({fetch_en_o, exec_busy_o, halted_o}));

    // R4: a fetch always follows execution unless the core parks.
    p_fetch_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_busy_o && exec_last && cls_q != CLS_HALT) |=> fetch_en_o);

endmodule

// File: tb/seq_cycle_timer_tb_top.sv
module seq_cycle_timer_tb_top;

    localparam int WAIT_W = 8;
    localparam int PW     = 16;
    localparam int NREG   = 5;
    localparam int NVEC   = 14;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [2:0]         ins_class_i = 3'd0;
    logic [WAIT_W-1:0]  wait_cnt_i = '0;
    logic [2:0]         sleep_sel_i = '0;
    logic [NREG*PW-1:0] period_regs_i;
    logic               timer_en_i = 1'b0;
    logic               bus_grant_i = 1'b1;
    logic               fetch_en_o, exec_busy_o, halted_o, timer_restart_o;
    logic [PW-1:0]      period_o;

    int checks = 0;
    int errors = 0;
    int prev_cls = 4;
    int exp_sel = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seq_cycle_timer #(.WAIT_W(WAIT_W), .PW(PW), .NREG(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ins_class_i(ins_class_i),
        .wait_cnt_i(wait_cnt_i), .sleep_sel_i(sleep_sel_i),
        .period_regs_i(period_regs_i), .timer_en_i(timer_en_i),
        .bus_grant_i(bus_grant_i), .fetch_en_o(fetch_en_o),
        .exec_busy_o(exec_busy_o), .halted_o(halted_o),
        .timer_restart_o(timer_restart_o), .period_o(period_o)
    );

    // Vector: {class[2:0], wait[7:0], sel[2:0], fetch stall[3:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {3'd0, 8'd0,   3'd0, 4'd0},
        {3'd0, 8'd0,   3'd0, 4'd0},
        {3'd1, 8'd0,   3'd0, 4'd2},
        {3'd2, 8'd0,   3'd0, 4'd0},
        {3'd3, 8'd0,   3'd0, 4'd0},
        {3'd0, 8'd0,   3'd0, 4'd3},
        {3'd3, 8'd5,   3'd0, 4'd0},
        {3'd5, 8'd0,   3'd3, 4'd1},
        {3'd6, 8'd0,   3'd0, 4'd0},
        {3'd5, 8'd0,   3'd6, 4'd0},
        {3'd1, 8'd0,   3'd0, 4'd0},
        {3'd5, 8'd0,   3'd4, 4'd2},
        {3'd3, 8'd255, 3'd0, 4'd0},
        {3'd7, 8'd0,   3'd0, 4'd0}
    };

    function automatic logic [PW-1:0] slot_val(input int k);
        return PW'(16'h1100 * (k + 1) + k);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_exec(input int cls, input int w, input int est);
        if (cls == 3) return 2 + w;
        if (cls == 2) return 4 + est;
        return 2;
    endfunction

    // Runs one instruction starting at the negedge of its first fetch cycle.
    task automatic run_instr(input int cls, input int w, input int sel,
                             input int fst, input int est, input bit hold_start,
                             output int f, output int e);
        f = 0;
        e = 0;
        ins_class_i = 3'(cls);
        wait_cnt_i  = WAIT_W'(w);
        sleep_sel_i = 3'(sel);
        start_i     = hold_start;
        while (fetch_en_o && f < 1000) begin
            bus_grant_i = (f < fst) ? 1'b0 : 1'b1;
            f++;
            @(negedge clk);
        end
        while (exec_busy_o && e < 1000) begin
            bus_grant_i = (e < est) ? 1'b0 : 1'b1;
            e++;
            @(negedge clk);
        end
        bus_grant_i = 1'b1;
        start_i     = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int f, e, ef;
        for (int k = 0; k < NREG; k++) period_regs_i[k*PW +: PW] = slot_val(k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 halted", int'(halted_o), 1);
        chk("R1 fetch_en", int'(fetch_en_o), 0);
        chk("R1 exec_busy", int'(exec_busy_o), 0);
        chk("R1 timer_restart", int'(timer_restart_o), 0);
        chk("R1 period", int'(period_o), int'(slot_val(0)));

        // R5: start leaves halt into a 4-cycle fetch
        pulse_start();
        chk("R5 fetch after start", int'(fetch_en_o), 1);

        // Table walk: R2 R3 R4 R7 R8 R10
        for (int i = 0; i < NVEC; i++) begin
            int cls = int'(VEC[i][17:15]);
            int w   = int'(VEC[i][14:7]);
            int sel = int'(VEC[i][6:4]);
            int fst = int'(VEC[i][3:0]);
            ef = ((prev_cls == 0 || prev_cls == 1) ? 2 : 4) + fst;
            run_instr(cls, w, sel, fst, 0, 1'b0, f, e);
            chk($sformatf("R2/R8 fetch len vec %0d", i), f, ef);
            chk($sformatf("R3/R4 exec len vec %0d", i), e, exp_exec(cls, w, 0));
            if (cls == 5) begin
                if (sel < NREG) exp_sel = sel;
                chk($sformatf("R7 period vec %0d", i), int'(period_o), int'(slot_val(exp_sel)));
            end
            prev_cls = cls;
        end

        // R9: memory execute stretched by stalls, ALU execute unaffected
        run_instr(2, 0, 0, 0, 3, 1'b0, f, e);
        chk("R9 mem exec stall", e, 7);
        prev_cls = 2;
        run_instr(0, 0, 0, 0, 3, 1'b0, f, e);
        chk("R2 fetch after mem", f, 4);
        chk("R9 alu exec no stall", e, 2);
        prev_cls = 0;

        // R5: start held during fetch/exec has no effect
        run_instr(6, 0, 0, 0, 0, 1'b1, f, e);
        chk("R5 start ignored fetch", f, 2);
        chk("R5 start ignored exec", e, 2);

        // R6: halt with timer enabled
        timer_en_i = 1'b1;
        run_instr(4, 0, 0, 0, 0, 1'b0, f, e);
        chk("R3 halt exec", e, 2);
        chk("R5 halted after halt", int'(halted_o), 1);
        chk("R6 restart pulse", int'(timer_restart_o), 1);
        @(negedge clk);
        chk("R6 restart one cycle", int'(timer_restart_o), 0);
        repeat (5) @(negedge clk);
        chk("R5 still halted", int'(halted_o), 1);
        chk("R7 period kept over halt", int'(period_o), int'(slot_val(exp_sel)));

        // R5: restart then halt with timer disabled
        pulse_start();
        timer_en_i = 1'b0;
        run_instr(4, 0, 0, 0, 0, 1'b0, f, e);
        chk("R5 fetch after start len", f, 4);
        chk("R6 no restart when disabled", int'(timer_restart_o), 0);
        chk("R5 halted again", int'(halted_o), 1);

        // R4: wait of zero after restart
        pulse_start();
        run_instr(3, 0, 0, 0, 0, 1'b0, f, e);
        chk("R4 wait zero exec", e, 2);
        run_instr(0, 0, 0, 0, 0, 1'b0, f, e);
        chk("R4 fetch after wait", f, 4);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule